// File: doc/BRIEF.md
# Linear CCD Drive Clock Sequencer

This block produces every drive clock that a three-colour linear CCD sensor needs, all from one system clock. A line begins with a transfer-gate pulse that moves charge from the photosites into the shift registers. The pulse goes to the red, green and blue gate outputs at the same moment. It is framed by a static setup window and a static hold window on the transfer clocks. A burst of 7153 pixel periods follows. In each pixel period the two complementary transfer clocks toggle once, the last-stage hold clock follows the first transfer clock, and a reset pulse clears the output node.

For every pixel the block also emits a one-cycle strobe, a 13-bit pixel index and a two-bit class tag. A capture path downstream uses these to tell the leading and trailing dummy pixels, the shielded black-reference pixels and the 7078 image pixels apart. One request on `line_req` starts operation. From then on, lines repeat on their own. Each line lasts the programmed integration period in system cycles, and that period is raised to the shortest line the sequence can fit.

Top module: `lccd_clkgen`

## Requirements
- R1: During reset, and while idle after reset with no request, all three gate outputs, `node_rst` and `pix_vld` are low, `xfer_p1` and `last_hold` are high, and `xfer_p2` is low.
- R2: A `line_req` seen while idle starts a line. Counting the first cycle after the accepting edge as cycle 0, the three gate outputs go high together in cycles SETUP_CYC to SETUP_CYC+GATE_CYC-1 and are low at all other times.
- R3: `xfer_p2` is always the inverse of `xfer_p1`, and `last_hold` is always equal to `xfer_p1`.
- R4: From cycle 0 until HOLD_CYC cycles after the gate falls, `xfer_p1` stays high and no pixel strobe occurs. The first fall of `xfer_p1` comes exactly HOLD_CYC cycles after the gate falls.
- R5: The burst has exactly 7153 pixel periods of PIX_CYC cycles each. In each period `xfer_p1` is low for the first PIX_CYC/2 cycles and high for the rest. Outside the burst `xfer_p1` is high.
- R6: `node_rst` is high for the first RST_CYC cycles of every pixel period and is low outside the burst.
- R7: `pix_vld` is high for exactly one cycle, the first cycle of each pixel period. Pixel indices arrive in ascending order from 0 to 7152 across the burst.
- R8: When `pix_vld` is high, `pix_cls` encodes the pixel class as 0 for dummy, 1 for optical black and 2 for effective. Indices 0–12 are dummy, 13–61 are black, 62 is dummy, 63–7140 are effective and 7141–7152 are dummy. Code 3 never appears.
- R9: Lines repeat with no further request. Each line lasts max(`line_period`, SETUP_CYC+GATE_CYC+HOLD_CYC+7153·PIX_CYC) cycles. `line_period` is sampled on the edge where a line starts, so a change takes effect at the next line.
- R10: A `line_req` asserted while a line sequence is running has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_req | input | 1 | Start request, accepted only while idle |
| line_period | input | INT_W | Integration (line) period in system cycles |
| gate_r | output | 1 | Transfer-gate pulse, red line |
| gate_g | output | 1 | Transfer-gate pulse, green line |
| gate_b | output | 1 | Transfer-gate pulse, blue line |
| xfer_p1 | output | 1 | First transfer clock |
| xfer_p2 | output | 1 | Second transfer clock, inverse of the first |
| last_hold | output | 1 | Last-stage hold clock |
| node_rst | output | 1 | Output-node reset clock |
| pix_vld | output | 1 | One-cycle strobe at the start of each pixel |
| pix_idx | output | 13 | Pixel index within the line |
| pix_cls | output | 2 | Pixel class: 0 dummy, 1 black, 2 effective |

## Verification
A wrong sequencer state shows up at once as a gate pulse at the wrong time, or as a transfer-clock edge inside the gate's setup or hold window. The cycle-by-cycle comparison catches either in the first cycle it occurs. A pixel counter that slips shows up as a misplaced `node_rst` or `pix_vld` within one pixel period. It also shows up as a wrong index or class, and that error persists to the end of the burst. An error in the line-period latch or the clamp only appears at the boundary to the next line, so the bench runs three lines back to back and checks the start of a fourth.

// File: rtl/lccd_pkg.sv
// Shared types for the linear CCD clock sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package lccd_pkg;

    // Line sequencer phases, in the order a line walks through them.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_GATE  = 3'd2,
        ST_HOLD  = 3'd3,
        ST_BURST = 3'd4,
        ST_WAIT  = 3'd5
    } seq_st_t;

    // Pixel class tag delivered with each pixel strobe.
    typedef enum logic [1:0] {
        CLS_DUMMY = 2'd0,
        CLS_BLACK = 2'd1,
        CLS_EFF   = 2'd2
    } pix_cls_t;

endpackage

// File: rtl/lccd_seq.sv
// Line sequencer: setup, transfer-gate, hold, pixel burst, then a wait
// until the latched line period has elapsed. Lines then repeat on their own.
// Assumes: SETUP_CYC, GATE_CYC, HOLD_CYC >= 1, and the shortest line fits in INT_W bits.
module lccd_seq #(
    parameter int SETUP_CYC = 3,
    parameter int GATE_CYC  = 2,
    parameter int HOLD_CYC  = 3,
    parameter int BURST_CYC = 28612,
    parameter int INT_W     = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_req,
    input  logic [INT_W-1:0] line_period,
    input  logic             burst_last,
    output logic             gate,
    output logic             burst
);
    import lccd_pkg::*;

    localparam int MAXP  = (SETUP_CYC > GATE_CYC)
                         ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                         : ((GATE_CYC > HOLD_CYC) ? GATE_CYC : HOLD_CYC);
    localparam int CNT_W = $clog2(MAXP + 1);
    localparam int MINL  = SETUP_CYC + GATE_CYC + HOLD_CYC + BURST_CYC;
    localparam logic [INT_W-1:0] MINL_V  = INT_W'(MINL);
    localparam logic [CNT_W-1:0] SU_LAST = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] GW_LAST = CNT_W'(GATE_CYC - 1);
    localparam logic [CNT_W-1:0] HD_LAST = CNT_W'(HOLD_CYC - 1);

    seq_st_t          st;
    logic [CNT_W-1:0] cnt;
    logic [INT_W-1:0] line_cnt;
    logic [INT_W-1:0] per_lat;
    logic [INT_W-1:0] per_in;
    logic             line_end;

    // Raise the requested period to the shortest line that fits.
    assign per_in   = (line_period < MINL_V) ? MINL_V : line_period;
    // Last cycle of the current line.
    assign line_end = (line_cnt == per_lat - 1'b1);

    // Phase state, phase counter, line-position counter and period latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            line_cnt <= '0;
            per_lat  <= MINL_V;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (line_req) begin
                        st       <= ST_SETUP;
                        cnt      <= '0;
                        line_cnt <= '0;
                        per_lat  <= per_in;
                    end
                end
                ST_SETUP: begin
                    line_cnt <= line_cnt + 1'b1;
                    if (cnt == SU_LAST) begin
                        st  <= ST_GATE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_GATE: begin
                    line_cnt <= line_cnt + 1'b1;
                    if (cnt == GW_LAST) begin
                        st  <= ST_HOLD;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_HOLD: begin
                    line_cnt <= line_cnt + 1'b1;
                    if (cnt == HD_LAST) begin
                        st  <= ST_BURST;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_BURST, ST_WAIT: begin
                    if ((st == ST_WAIT || burst_last) && line_end) begin
                        st       <= ST_SETUP;
                        cnt      <= '0;
                        line_cnt <= '0;
                        per_lat  <= per_in;
                    end else begin
                        if (burst_last) st <= ST_WAIT;
                        line_cnt <= line_cnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign gate  = (st == ST_GATE);
    assign burst = (st == ST_BURST);

    // The burst is entered only from the hold phase.
    AST_BURST_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst) |-> $past(st) == ST_HOLD);  // R4
    // A line never outlasts its latched period.
    AST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |-> line_cnt < per_lat);  // R9

endmodule

// File: rtl/lccd_pixtim.sv
// Pixel timing: pixel-phase and index counters that run during the burst.
// They drive the transfer clock, the node reset and the per-pixel strobe.
// Assumes: PIX_CYC >= 2, 1 <= RST_CYC < PIX_CYC, and burst held for NPIX*PIX_CYC cycles.
module lccd_pixtim #(
    parameter int PIX_CYC = 4,
    parameter int RST_CYC = 1,
    parameter int NPIX    = 7153,
    parameter int IDX_W   = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst,
    output logic             p1,
    output logic             rs,
    output logic             vld,
    output logic [IDX_W-1:0] idx,
    output logic             burst_last
);
    localparam int PH_W = $clog2(PIX_CYC);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(PIX_CYC - 1);
    localparam logic [PH_W-1:0]  PH_HALF  = PH_W'(PIX_CYC / 2);
    localparam logic [PH_W-1:0]  PH_RST   = PH_W'(RST_CYC);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NPIX - 1);

    logic [PH_W-1:0]  ph;
    logic [IDX_W-1:0] cnt_idx;

    // Phase within the pixel and pixel index; cleared outside the burst.
    always_ff @(posedge clk) begin
        if (!rst_n || !burst) begin
            ph      <= '0;
            cnt_idx <= '0;
        end else if (ph == PH_LAST) begin
            ph      <= '0;
            cnt_idx <= cnt_idx + 1'b1;
        end else begin
            ph <= ph + 1'b1;
        end
    end

    assign burst_last = burst && (ph == PH_LAST) && (cnt_idx == IDX_LAST);
    assign p1         = !burst || (ph >= PH_HALF);
    assign rs         = burst && (ph < PH_RST);
    assign vld        = burst && (ph == '0);
    assign idx        = burst ? cnt_idx : '0;

    // Each new pixel index is one above the index in the cycle before.
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && idx != '0) |-> $past(idx) == idx - 1'b1);  // R7
    // The reset pulse always starts together with the pixel strobe.
    AST_RST_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rs) |-> vld);  // R6

endmodule

// File: rtl/lccd_pixmap.sv
// Pixel map: classifies a pixel index as dummy, optical black or effective.
// Assumes: BLACK_FIRST + BLACK_N <= LEAD_N.
module lccd_pixmap #(
    parameter int LEAD_N      = 63,
    parameter int BLACK_FIRST = 13,
    parameter int BLACK_N     = 49,
    parameter int EFF_N       = 7078,
    parameter int IDX_W       = 13
) (
    input  logic [IDX_W-1:0]     idx,
    output lccd_pkg::pix_cls_t   cls
);
    import lccd_pkg::*;

    localparam logic [IDX_W-1:0] B_LO = IDX_W'(BLACK_FIRST);
    localparam logic [IDX_W-1:0] B_HI = IDX_W'(BLACK_FIRST + BLACK_N);
    localparam logic [IDX_W-1:0] E_LO = IDX_W'(LEAD_N);
    localparam logic [IDX_W-1:0] E_HI = IDX_W'(LEAD_N + EFF_N);

    // Range decode of the index into a class.
    always_comb begin
        if (idx >= B_LO && idx < B_HI)      cls = CLS_BLACK;
        else if (idx >= E_LO && idx < E_HI) cls = CLS_EFF;
        else                                cls = CLS_DUMMY;
    end

endmodule

// File: rtl/lccd_clkgen.sv
// Top: linear CCD drive clock sequencer. Joins the line sequencer,
// the pixel timing and the pixel map, and fans the gate out to three colours.
// Assumes: parameter constraints of the submodules; one system clock domain.
module lccd_clkgen #(
    parameter int SETUP_CYC   = 3,
    parameter int GATE_CYC    = 2,
    parameter int HOLD_CYC    = 3,
    parameter int PIX_CYC     = 4,
    parameter int RST_CYC     = 1,
    parameter int LEAD_N      = 63,
    parameter int BLACK_FIRST = 13,
    parameter int BLACK_N     = 49,
    parameter int EFF_N       = 7078,
    parameter int TAIL_N      = 12,
    parameter int INT_W       = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_req,
    input  logic [INT_W-1:0] line_period,
    output logic             gate_r,
    output logic             gate_g,
    output logic             gate_b,
    output logic             xfer_p1,
    output logic             xfer_p2,
    output logic             last_hold,
    output logic             node_rst,
    output logic             pix_vld,
    output logic [12:0]      pix_idx,
    output logic [1:0]       pix_cls
);
    localparam int NPIX  = LEAD_N + EFF_N + TAIL_N;
    localparam int IDX_W = 13;

    logic             gate;
    logic             burst;
    logic             burst_last;
    logic             p1;
    logic [IDX_W-1:0] idx;
    lccd_pkg::pix_cls_t cls;

    lccd_seq #(
        .SETUP_CYC (SETUP_CYC),
        .GATE_CYC  (GATE_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .BURST_CYC (NPIX * PIX_CYC),
        .INT_W     (INT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_req    (line_req),
        .line_period (line_period),
        .burst_last  (burst_last),
        .gate        (gate),
        .burst       (burst)
    );

    lccd_pixtim #(
        .PIX_CYC (PIX_CYC),
        .RST_CYC (RST_CYC),
        .NPIX    (NPIX),
        .IDX_W   (IDX_W)
    ) u_pixtim (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst      (burst),
        .p1         (p1),
        .rs         (node_rst),
        .vld        (pix_vld),
        .idx        (idx),
        .burst_last (burst_last)
    );

    lccd_pixmap #(
        .LEAD_N      (LEAD_N),
        .BLACK_FIRST (BLACK_FIRST),
        .BLACK_N     (BLACK_N),
        .EFF_N       (EFF_N),
        .IDX_W       (IDX_W)
    ) u_pixmap (
        .idx (idx),
        .cls (cls)
    );

    // All three colour gates carry the same pulse.
    assign gate_r    = gate;
    assign gate_g    = gate;
    assign gate_b    = gate;
    assign xfer_p1   = p1;
    assign xfer_p2   = !p1;
    assign last_hold = p1;
    assign pix_idx   = idx;
    assign pix_cls   = cls;

    // The transfer clock stays high and no pixel is strobed while the gate is open.
    AST_STATIC_UNDER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (xfer_p1 && !pix_vld));  // R4
    // A transfer-clock fall never directly follows an open gate.
    AST_HOLD_AFTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_p1) |-> !$past(gate));  // R4
    // The reserved class code never accompanies a strobe.
    AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |-> (pix_cls != 2'd3));  // R8

endmodule

// File: tb/lccd_clkgen_bench.sv
// Directed bench for lccd_clkgen: one task per scenario, comparing every
// cycle against a timing model derived from the requirements.
module lccd_clkgen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SU   = 3;
    localparam int GW   = 2;
    localparam int HD   = 3;
    localparam int PC   = 4;
    localparam int RW   = 1;
    localparam int NPIX = 7153;
    localparam int MINL = SU + GW + HD + NPIX * PC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_req = 1'b0;
    logic [19:0] line_period = '0;
    logic        gate_r, gate_g, gate_b;
    logic        xfer_p1, xfer_p2, last_hold, node_rst, pix_vld;
    logic [12:0] pix_idx;
    logic [1:0]  pix_cls;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    lccd_clkgen u_lccd_clkgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_req    (line_req),
        .line_period (line_period),
        .gate_r      (gate_r),
        .gate_g      (gate_g),
        .gate_b      (gate_b),
        .xfer_p1     (xfer_p1),
        .xfer_p2     (xfer_p2),
        .last_hold   (last_hold),
        .node_rst    (node_rst),
        .pix_vld     (pix_vld),
        .pix_idx     (pix_idx),
        .pix_cls     (pix_cls)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // One comparison; a mismatch prints a FAIL line (first 25 only).
    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            if (n_bad <= 25)
                $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // Class expected for an index, per the R8 map.
    function automatic int exp_cls(input int i);
        if (i >= 13 && i <= 61)   return 1;
        if (i >= 63 && i <= 7140) return 2;
        return 0;
    endfunction

    // Compare all outputs at offset k within the current line.
    task automatic check_cycle(input int k);
        int b0 = SU + GW + HD;
        bit in_b = (k >= b0) && (k < b0 + NPIX * PC);
        int ph = in_b ? (k - b0) % PC : 0;
        int ix = in_b ? (k - b0) / PC : 0;
        bit e_gate = (k >= SU) && (k < SU + GW);
        bit e_p1 = !in_b || (ph >= PC / 2);
        chk("R2", "gate_r", int'(gate_r), int'(e_gate));
        chk("R2", "gate_g", int'(gate_g), int'(e_gate));
        chk("R2", "gate_b", int'(gate_b), int'(e_gate));
        chk((k < b0) ? "R4" : "R5", "xfer_p1", int'(xfer_p1), int'(e_p1));
        chk("R3", "xfer_p2", int'(xfer_p2), int'(!e_p1));
        chk("R3", "last_hold", int'(last_hold), int'(e_p1));
        chk("R6", "node_rst", int'(node_rst), int'(in_b && ph < RW));
        chk("R7", "pix_vld", int'(pix_vld), int'(in_b && ph == 0));
        if (in_b && ph == 0) begin
            chk("R7", "pix_idx", int'(pix_idx), ix);
            chk("R8", "pix_cls", int'(pix_cls), exp_cls(ix));
        end
    endtask

    // Idle/reset output values.
    task automatic check_idle(input string req);
        chk(req, "gates", int'({gate_r, gate_g, gate_b}), 0);
        chk(req, "xfer_p1", int'(xfer_p1), 1);
        chk(req, "xfer_p2", int'(xfer_p2), 0);
        chk(req, "last_hold", int'(last_hold), 1);
        chk(req, "node_rst", int'(node_rst), 0);
        chk(req, "pix_vld", int'(pix_vld), 0);
    endtask

    // Scenario: reset values, then idle with no request (R1).
    task automatic t_reset_idle();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            check_idle("R1");
        end
    endtask

    // Scenario: run one line of period p; optionally poke line_req mid-line (R10)
    // and change line_period mid-line (R9, applies to the next line).
    task automatic t_line(input int p, input bit poke, input int new_per);
        for (int k = 0; k < p; k++) begin
            check_cycle(k);
            line_req = poke && (k == 1000 || k == SU);
            if (k == p / 2 && new_per >= 0) line_period = 20'(new_per);
            @(negedge clk);
        end
        line_req = 1'b0;
    endtask

    // Scenario: start of the next line after the previous one (R9 repeat).
    task automatic t_line_head();
        for (int k = 0; k < SU + GW + HD + 3 * PC; k++) begin
            check_cycle(k);
            @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset_idle();
        // R2: request from idle; period below the minimum is clamped (R9).
        line_period = 20'd100;
        line_req = 1'b1;
        @(negedge clk);
        line_req = 1'b0;
        t_line(MINL, 1'b1, -1);            // R10 pokes inside the line
        t_line(MINL, 1'b0, MINL + 37);     // R9 new period for the next line
        t_line(MINL + 37, 1'b1, -1);       // R9 longer line, R10 again
        t_line_head();                     // R9 automatic restart
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule